// File: doc/BRIEF.md
# Dual-Clock Serial Field Delay Memory

This block is a nibble-wide serial memory with a write port and a read port that run on unrelated clocks, possibly at different rates. Each port walks through the storage with its own address pointer. The pointers never run free: each one only moves once its port has seen a sampled pointer-reset on its own clock. The distance between the two streams is therefore set only by when each port is reset, which makes the block a programmable digital delay line, for example one video field long.

Each port has two levels of gating. The step input stalls the pointer. The second input gates only the data and lets the pointer keep moving. On the write side this second input is a pass flag: when it is low, the addressed word keeps its old contents, which allows masked insertion such as picture-in-picture. On the read side it is a show flag: when it is low, the output is blanked. The write path holds each accepted nibble in a staging register and commits it to the array one write cycle later. The read path has a registered output.

The write side has three states. WS_CLEAR sweeps zero into every word after reset and moves to WS_IDLE when the sweep reaches the last address. WS_IDLE ignores data until the first write reset, which moves it to WS_FILL. WS_FILL stays in WS_FILL, and each write reset starts a new pass. The read side has two states. RS_IDLE goes to RS_RUN on the first read reset, and RS_RUN stays in RS_RUN. Two one-cycle flags report write-side protocol errors: a write reset that comes too early, and a pass that is too short.

Top module: `fieldmem_delay`

## Requirements
- R1: After wr_arst_n is released, the write side spends DEPTH write cycles in WS_CLEAR writing zero to every address, then waits in WS_IDLE. In WS_IDLE, wr_step, wr_pass and wr_data are ignored. A read of any location not written since then returns 0. Directly after reset, rd_data, wr_zero_err and wr_short_err are 0.
- R2: A write-clock edge that samples wr_zero high, in WS_IDLE or WS_FILL, sets the write pointer to 0. On that edge wr_step, wr_pass and wr_data are ignored.
- R3: In WS_FILL, an edge with wr_zero low and wr_step high accepts wr_data for the current address and advances the write pointer. An edge with wr_step low accepts nothing and holds the pointer.
- R4: An accepted nibble with wr_pass low leaves the addressed word unchanged, but the pointer still advances.
- R5: An accepted nibble is written into the array on the write-clock edge after the one that accepted it.
- R6: Both pointers wrap from DEPTH-1 to 0.
- R7: A read-clock edge that samples rd_zero high sets the read pointer to 0, makes rd_data 0 for the following cycle, and moves RS_IDLE to RS_RUN.
- R8: In RS_RUN, an edge with rd_step high loads the word at the read pointer into the output register and advances the pointer. With rd_step low, both the pointer and the output word hold.
- R9: When a read edge samples rd_show low, rd_data is 0 for the following read cycle, and the pointer still advances if rd_step is high.
- R10: A write reset in WS_FILL that comes after fewer than two write cycles with wr_zero low since the previous write reset raises wr_zero_err for one write cycle.
- R11: A write reset in WS_FILL that ends a pass with fewer than MIN_PASS accepted nibbles raises wr_short_err for one write cycle.
- R12: The two ports run on independent clocks with different periods. Data written in a pass is read back in write order from the read reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_arst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_zero | input | 1 | Sampled write-pointer reset |
| wr_step | input | 1 | Write enable: accept a nibble and advance |
| wr_pass | input | 1 | Write mask: low keeps the addressed word |
| wr_data | input | DW | Write nibble |
| wr_zero_err | output | 1 | Write reset came too early (one cycle) |
| wr_short_err | output | 1 | Write pass was too short (one cycle) |
| rd_clk | input | 1 | Read clock |
| rd_arst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_zero | input | 1 | Sampled read-pointer reset |
| rd_step | input | 1 | Read enable: fetch a word and advance |
| rd_show | input | 1 | Output enable: low blanks rd_data |
| rd_data | output | DW | Registered read nibble |

## Verification
The hardest situations to reach from the ports are the protocol faults: a write reset that follows the previous one after only one or zero low cycles, and a pass cut short before MIN_PASS nibbles. The stimulus reaches them after a series of legal passes by issuing back-to-back write resets with two, one and then no intervening cycles, so that each flag is seen both firing and staying quiet. A second hard case is the one-cycle commit lag combined with wrap-around. It is exercised by passes that write DEPTH+3 masked nibbles, so that the first addresses are overwritten and the last nibble is committed only by the following idle write cycle before the read pass begins.

// File: rtl/fdm_pkg.sv
`timescale 1ns/1ps
package fdm_pkg;
    typedef enum logic [1:0] {
        WS_CLEAR = 2'd0,
        WS_IDLE  = 2'd1,
        WS_FILL  = 2'd2
    } wr_state_t;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } rd_state_t;
endpackage

// File: rtl/fdm_store.sv
`timescale 1ns/1ps
module fdm_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdin,
    input  logic          rd_clk,
    input  logic          rd_arst_n,
    input  logic          re,
    input  logic          rclr,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdin;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_arst_n) begin
        if (!rd_arst_n) begin
            rword <= '0;
        end else if (rclr) begin
            rword <= '0;
        end else if (re) begin
            rword <= cells[raddr];
        end
    end
endmodule

// File: rtl/fdm_wr_ctrl.sv
`timescale 1ns/1ps
module fdm_wr_ctrl
    import fdm_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int DW       = 4,
    parameter int MIN_PASS = 16,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(MIN_PASS + 1)
) (
    input  logic          wr_clk,
    input  logic          wr_arst_n,
    input  logic          wr_zero,
    input  logic          wr_step,
    input  logic          wr_pass,
    input  logic [DW-1:0] wr_data,
    output logic          wr_zero_err,
    output logic          wr_short_err,
    output wr_state_t     state,
    output logic [AW-1:0] ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_din
);
    localparam logic [AW-1:0] LAST      = AW'(DEPTH - 1);
    localparam logic [CW-1:0] PASS_FULL = CW'(MIN_PASS);
    localparam logic [1:0]    GAP_OK    = 2'd2;

    wr_state_t     state_nxt;
    logic [AW-1:0] ptr_inc;
    logic          stage_vld;
    logic          stage_keep;
    logic [AW-1:0] stage_addr;
    logic [DW-1:0] stage_data;
    logic [1:0]    gap_cnt;
    logic [CW-1:0] pass_cnt;

    assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;

    // state register
    always_ff @(posedge wr_clk or negedge wr_arst_n) begin
        if (!wr_arst_n) begin
            state <= WS_CLEAR;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            WS_CLEAR: state_nxt = (ptr == LAST) ? WS_IDLE : WS_CLEAR;
            WS_IDLE:  state_nxt = wr_zero ? WS_FILL : WS_IDLE;
            WS_FILL:  state_nxt = WS_FILL;
            default:  state_nxt = WS_CLEAR;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge wr_clk or negedge wr_arst_n) begin
        if (!wr_arst_n) begin
            ptr          <= '0;
            stage_vld    <= 1'b0;
            stage_keep   <= 1'b0;
            stage_addr   <= '0;
            stage_data   <= '0;
            gap_cnt      <= GAP_OK;
            pass_cnt     <= '0;
            wr_zero_err  <= 1'b0;
            wr_short_err <= 1'b0;
        end else begin
            stage_vld    <= 1'b0;
            wr_zero_err  <= 1'b0;
            wr_short_err <= 1'b0;
            unique case (state)
                WS_CLEAR: begin
                    ptr <= ptr_inc;
                end
                WS_IDLE: begin
                    if (wr_zero) begin
                        ptr      <= '0;
                        gap_cnt  <= '0;
                        pass_cnt <= '0;
                    end
                end
                WS_FILL: begin
                    if (wr_zero) begin
                        ptr          <= '0;
                        gap_cnt      <= '0;
                        pass_cnt     <= '0;
                        wr_zero_err  <= (gap_cnt < GAP_OK);
                        wr_short_err <= (pass_cnt < PASS_FULL);
                    end else begin
                        if (gap_cnt != GAP_OK) begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                        if (wr_step) begin
                            stage_vld  <= 1'b1;
                            stage_keep <= wr_pass;
                            stage_addr <= ptr;
                            stage_data <= wr_data;
                            ptr        <= ptr_inc;
                            if (pass_cnt != PASS_FULL) begin
                                pass_cnt <= pass_cnt + 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    ptr <= '0;
                end
            endcase
        end
    end

    // array write port: sweep in WS_CLEAR, staged commit otherwise
    always_comb begin
        if (state == WS_CLEAR) begin
            mem_we   = 1'b1;
            mem_addr = ptr;
            mem_din  = '0;
        end else begin
            mem_we   = stage_vld & stage_keep;
            mem_addr = stage_addr;
            mem_din  = stage_data;
        end
    end
endmodule

// File: rtl/fdm_rd_ctrl.sv
`timescale 1ns/1ps
module fdm_rd_ctrl
    import fdm_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rd_clk,
    input  logic          rd_arst_n,
    input  logic          rd_zero,
    input  logic          rd_step,
    input  logic          rd_show,
    input  logic [DW-1:0] rword,
    output rd_state_t     state,
    output logic [AW-1:0] ptr,
    output logic          mem_re,
    output logic          mem_clr,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rd_state_t state_nxt;
    logic      show_q;

    always_ff @(posedge rd_clk or negedge rd_arst_n) begin
        if (!rd_arst_n) begin
            state <= RS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RS_IDLE: state_nxt = rd_zero ? RS_RUN : RS_IDLE;
            RS_RUN:  state_nxt = RS_RUN;
            default: state_nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_arst_n) begin
        if (!rd_arst_n) begin
            ptr    <= '0;
            show_q <= 1'b0;
        end else begin
            show_q <= rd_show;
            if (rd_zero) begin
                ptr <= '0;
            end else if (state == RS_RUN && rd_step) begin
                ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
            end
        end
    end

    always_comb begin
        mem_re  = (state == RS_RUN) && !rd_zero && rd_step;
        mem_clr = rd_zero;
        rd_data = show_q ? rword : '0;
    end
endmodule

// File: rtl/fieldmem_delay.sv
`timescale 1ns/1ps
module fieldmem_delay
    import fdm_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int DW       = 4,
    parameter int MIN_PASS = 16,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_arst_n,
    input  logic          wr_zero,
    input  logic          wr_step,
    input  logic          wr_pass,
    input  logic [DW-1:0] wr_data,
    output logic          wr_zero_err,
    output logic          wr_short_err,
    input  logic          rd_clk,
    input  logic          rd_arst_n,
    input  logic          rd_zero,
    input  logic          rd_step,
    input  logic          rd_show,
    output logic [DW-1:0] rd_data
);
    wr_state_t     wst;
    rd_state_t     rst_q;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          m_we;
    logic [AW-1:0] m_waddr;
    logic [DW-1:0] m_wdin;
    logic          m_re;
    logic          m_rclr;
    logic [DW-1:0] m_rword;

    fdm_wr_ctrl #(.DEPTH(DEPTH), .DW(DW), .MIN_PASS(MIN_PASS)) u_wr (
        .wr_clk       (wr_clk),
        .wr_arst_n    (wr_arst_n),
        .wr_zero      (wr_zero),
        .wr_step      (wr_step),
        .wr_pass      (wr_pass),
        .wr_data      (wr_data),
        .wr_zero_err  (wr_zero_err),
        .wr_short_err (wr_short_err),
        .state        (wst),
        .ptr          (wptr),
        .mem_we       (m_we),
        .mem_addr     (m_waddr),
        .mem_din      (m_wdin)
    );

    fdm_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .wr_clk    (wr_clk),
        .we        (m_we),
        .waddr     (m_waddr),
        .wdin      (m_wdin),
        .rd_clk    (rd_clk),
        .rd_arst_n (rd_arst_n),
        .re        (m_re),
        .rclr      (m_rclr),
        .raddr     (rptr),
        .rword     (m_rword)
    );

    fdm_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
        .rd_clk    (rd_clk),
        .rd_arst_n (rd_arst_n),
        .rd_zero   (rd_zero),
        .rd_step   (rd_step),
        .rd_show   (rd_show),
        .rword     (m_rword),
        .state     (rst_q),
        .ptr       (rptr),
        .mem_re    (m_re),
        .mem_clr   (m_rclr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/fdm_checker.sv
`timescale 1ns/1ps
module fdm_checker
    import fdm_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          wr_clk,
    input logic          wr_arst_n,
    input logic          wr_zero,
    input logic          wr_step,
    input logic          wr_pass,
    input wr_state_t     wst,
    input logic [AW-1:0] wptr,
    input logic          m_we,
    input logic          rd_clk,
    input logic          rd_arst_n,
    input logic          rd_zero,
    input logic          rd_step,
    input logic          rd_show,
    input logic [AW-1:0] rptr,
    input logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // R2: sampled write reset returns the pointer to zero
    p_wr_zero_r2: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
        (wst != WS_CLEAR && wr_zero) |=> (wptr == '0));

    // R3: no step, no movement
    p_wr_hold_r3: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
        (wst == WS_FILL && !wr_zero && !wr_step) |=> $stable(wptr));

    // R5: an array write in a pass follows an accepted, unmasked nibble
    p_commit_lag_r5: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
        (wst == WS_FILL && m_we) |-> $past(wst == WS_FILL && wr_step && wr_pass && !wr_zero));

    // R6: write pointer wraps
    p_wr_wrap_r6: assert property (@(posedge wr_clk) disable iff (!wr_arst_n)
        (wst == WS_FILL && !wr_zero && wr_step && wptr == LAST) |=> (wptr == '0));

    // R7: read reset clears pointer and output
    p_rd_zero_r7: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
        rd_zero |=> (rptr == '0 && rd_data == '0));

    // R8: no read step, no movement
    p_rd_hold_r8: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
        (!rd_zero && !rd_step) |=> $stable(rptr));

    // R9: blanking
    p_blank_r9: assert property (@(posedge rd_clk) disable iff (!rd_arst_n)
        !rd_show |=> (rd_data == '0));
endmodule

bind fieldmem_delay fdm_checker #(.DEPTH(DEPTH), .DW(DW)) u_fdm_checker (
    .wr_clk    (wr_clk),
    .wr_arst_n (wr_arst_n),
    .wr_zero   (wr_zero),
    .wr_step   (wr_step),
    .wr_pass   (wr_pass),
    .wst       (wst),
    .wptr      (wptr),
    .m_we      (m_we),
    .rd_clk    (rd_clk),
    .rd_arst_n (rd_arst_n),
    .rd_zero   (rd_zero),
    .rd_step   (rd_step),
    .rd_show   (rd_show),
    .rptr      (rptr),
    .rd_data   (rd_data)
);

// File: tb/test_fieldmem_delay.sv
`timescale 1ns/1ps
module test_fieldmem_delay;
    localparam int DEPTH = 16;
    localparam int DW    = 4;
    localparam int MINP  = 5;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic wr_arst_n = 1'b0;
    logic rd_arst_n = 1'b0;
    logic wr_zero = 1'b0, wr_step = 1'b0, wr_pass = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_zero = 1'b0, rd_step = 1'b0, rd_show = 1'b0;
    logic wr_zero_err, wr_short_err;
    logic [DW-1:0] rd_data;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;   // independent read clock

    fieldmem_delay #(.DEPTH(DEPTH), .DW(DW), .MIN_PASS(MINP)) i_fieldmem_delay (
        .wr_clk(wr_clk), .wr_arst_n(wr_arst_n), .wr_zero(wr_zero), .wr_step(wr_step),
        .wr_pass(wr_pass), .wr_data(wr_data), .wr_zero_err(wr_zero_err),
        .wr_short_err(wr_short_err), .rd_clk(rd_clk), .rd_arst_n(rd_arst_n),
        .rd_zero(rd_zero), .rd_step(rd_step), .rd_show(rd_show), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];
    int  wp = 0, lows = 0, passes = 0;
    bit  w_armed = 0;
    int  rp = 0;
    logic [DW-1:0] rword = '0;
    bit  r_armed = 0;

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cyc(input logic z, input logic s, input logic p, input logic [DW-1:0] d);
        logic ez, es;
        @(negedge wr_clk);
        wr_zero = z; wr_step = s; wr_pass = p; wr_data = d;
        @(posedge wr_clk);
        #1;
        ez = 1'b0; es = 1'b0;
        if (z) begin
            if (w_armed) begin
                ez = (lows < 2);
                es = (passes < MINP);
            end
            w_armed = 1; wp = 0; lows = 0; passes = 0;
        end else if (w_armed) begin
            lows++;
            if (s) begin
                if (p) model[wp] = d;
                wp = (wp + 1) % DEPTH;
                passes++;
            end
        end
        check({3'b0, wr_zero_err}, {3'b0, ez}, "R10 spacing flag");
        check({3'b0, wr_short_err}, {3'b0, es}, "R11 short-pass flag");
    endtask

    task automatic rd_cyc(input logic z, input logic s, input logic sh, input string req);
        @(negedge rd_clk);
        rd_zero = z; rd_step = s; rd_show = sh;
        @(posedge rd_clk);
        #1;
        if (z) begin
            r_armed = 1; rp = 0; rword = '0;
        end else if (r_armed && s) begin
            rword = model[rp];
            rp = (rp + 1) % DEPTH;
        end
        check(rd_data, sh ? rword : '0, req);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge wr_clk);
        #1;
        check(rd_data, '0, "R1 reset rd_data");
        check({3'b0, wr_zero_err}, 4'h0, "R1 reset zero_err");
        check({3'b0, wr_short_err}, 4'h0, "R1 reset short_err");
        wr_arst_n = 1'b1; rd_arst_n = 1'b1;
        repeat (DEPTH + 4) @(posedge wr_clk);

        // R1: writes before the first write reset are ignored
        wr_cyc(0, 1, 1, 4'hA);
        wr_cyc(0, 0, 0, 4'h0);
        rd_cyc(1, 0, 1, "R7 read reset");
        for (int i = 0; i < DEPTH; i++) rd_cyc(0, 1, 1, "R1 cleared word");

        // R2/R3: full pass, step and data on the reset edge ignored
        wr_cyc(1, 1, 1, 4'h5);
        for (int i = 0; i < DEPTH; i++) wr_cyc(0, 1, 1, DW'((i * 7 + 3) % 16));
        wr_cyc(0, 0, 1, 4'h0);
        rd_cyc(1, 1, 1, "R7 read reset with step");
        for (int i = 0; i < DEPTH + 2; i++) rd_cyc(0, 1, 1, "R2 R3 R6 R12 readback");

        // R4/R5/R6: masked pass that wraps
        wr_cyc(1, 0, 1, 4'h0);
        for (int i = 0; i < DEPTH + 3; i++) wr_cyc(0, 1, (i % 3) != 0, DW'((i * 5 + 1) % 16));
        wr_cyc(0, 0, 1, 4'h0);
        rd_cyc(1, 0, 1, "R7 read reset");
        for (int i = 0; i < DEPTH; i++) rd_cyc(0, 1, 1, "R4 R5 R6 masked readback");

        // R3: write enable low holds the pointer
        wr_cyc(1, 0, 1, 4'h0);
        for (int i = 0; i < 3; i++) wr_cyc(0, 1, 1, DW'(i + 8));
        for (int i = 0; i < 4; i++) wr_cyc(0, 0, 1, 4'hF);
        for (int i = 0; i < 3; i++) wr_cyc(0, 1, 1, DW'(i + 12));
        wr_cyc(0, 0, 1, 4'h0);

        // R8/R9: read hold and blanking
        rd_cyc(1, 0, 1, "R7 read reset");
        for (int i = 0; i < 2; i++) rd_cyc(0, 1, 1, "R3 R8 read");
        for (int i = 0; i < 3; i++) rd_cyc(0, 0, 1, "R8 hold");
        for (int i = 0; i < 2; i++) rd_cyc(0, 1, 0, "R9 blank");
        for (int i = 0; i < 4; i++) rd_cyc(0, 1, 1, "R3 R9 after blank");
        rd_cyc(0, 0, 0, "R9 blank while held");
        rd_cyc(0, 0, 1, "R8 word held");

        // R10/R11: protocol faults
        wr_cyc(1, 0, 1, 4'h0);
        wr_cyc(0, 1, 1, 4'h1);
        wr_cyc(0, 1, 1, 4'h2);
        wr_cyc(1, 0, 1, 4'h0);   // short pass
        wr_cyc(0, 0, 1, 4'h0);
        wr_cyc(1, 0, 1, 4'h0);   // one low cycle only
        wr_cyc(1, 0, 1, 4'h0);   // no low cycle
        wr_cyc(0, 0, 1, 4'h0);
        wr_cyc(0, 0, 1, 4'h0);
        wr_cyc(0, 0, 1, 4'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule